// File: doc/BRIEF.md
# Banked Memory-Map Decoder with Object-DMA Arbitration

This block sits between an 8-bit-data CPU with a 16-bit address bus and the memories and register files of the system. For every read or write it decides which target the access belongs to: the fixed ROM bank, the switchable ROM bank, video RAM, external RAM, the two work RAM windows, object attribute RAM, the I/O register file, high RAM or the interrupt-enable register. For each access it drives a one-hot target select, the offset inside that target and read and write strobes. Writes into the ROM window never reach ROM. They are passed on as control writes to the external bank controller.

While an object DMA transfer is running, the block refuses any CPU access that would compete with the DMA for the same internal bus. It does this by assigning each 8 KB slice of the address space to a bus group. Two group tables exist: in the basic variant the work RAM slice shares the main bus, and in the enhanced variant it has a bus of its own. The block also hides video RAM and object attribute RAM from the CPU while the video engine owns them. Refused or unmapped reads return 0xFF, and refused writes do nothing.

The block contains one register of its own, the work RAM bank register. This register picks which physical bank appears in the switchable work RAM window.

Top module: `memmap_steer`

## Requirements
- R1: With `cpu_rd` or `cpu_wr` high and nothing blocking, `tgt_sel` is one-hot and decodes as follows: bit0 0x0000-0x3FFF, bit1 0x4000-0x7FFF, bit2 0x8000-0x9FFF, bit3 0xA000-0xBFFF, bit4 0xC000-0xCFFF, bit5 0xD000-0xDFFF, bit6 0xFE00-0xFE9F, bit7 0xFF00-0xFF7F except the bank register address, bit8 0xFF80-0xFFFE, bit9 0xFFFF. `tgt_off` is the address masked to the size of its window: 14 bits for ROM, 13 bits for video RAM and external RAM, 12 bits for work RAM, 8 bits for object RAM, 7 bits for I/O and high RAM, and 0 for the interrupt-enable register.
- R2: The mirror region is split in two. 0xE000-0xEFFF selects bit4 and 0xF000-0xFDFF selects bit5, each with offset `addr[11:0]`.
- R3: The work RAM bank register sits at address 0xFF70 (parameter `BANK_ADDR`) and resets to 1. A write stores `wdata[2:0]`, and a stored value of 0 becomes 1. A read returns `{5'b11111, bank}`. `wram_page` equals the bank while bit5 is selected and is 0 otherwise.
- R4: A write anywhere in 0x0000-0x7FFF pulses `ctl_wr` and never raises `tgt_wr`.
- R5: While `vid_mode` is 3, video RAM is unreachable. No select is raised, reads return 0xFF and writes are dropped.
- R6: Object attribute RAM is reachable only while `vid_mode` is 0 or 1. In the other modes it behaves as in R5.
- R7: While `dma_active` is high, an access is blocked when its address slice (bits 15:13) is in the same bus group as `dma_slice`. The basic group table is: slices 0-3 main, 4 video, 5-6 main, 7 CPU-internal. A blocked access raises no select, no strobe and no `ctl_wr`, and reads return 0xFF.
- R8: When `hw_enh` is high, slice 6 (0xC000-0xDFFF) forms its own work RAM group. The rest of the table is unchanged.
- R9: Accesses are never blocked by the group rule when the shared group is the CPU-internal one (slice 7).
- R10: While `dma_active` is high, every access to 0xFE00-0xFE9F is blocked, whatever the group or video mode.
- R11: The hole 0xFEA0-0xFEFF selects nothing and reads 0xFF.
- R12: When a read selects a target, `cpu_rdata` equals `tgt_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_enh | input | 1 | Selects the enhanced bus-group table |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| dma_active | input | 1 | Object DMA transfer in progress |
| dma_slice | input | 3 | Bits 15:13 of the current DMA source address |
| vid_mode | input | 2 | Current video engine mode |
| tgt_sel | output | 10 | One-hot target select |
| tgt_off | output | 14 | Offset inside the selected target |
| tgt_rd | output | 1 | Read strobe to the selected target |
| tgt_wr | output | 1 | Write strobe to the selected target |
| tgt_wdata | output | 8 | Write data to the targets |
| tgt_rdata | input | 8 | Read data from the selected target |
| ctl_wr | output | 1 | Control write to the ROM bank controller |
| wram_page | output | 3 | Physical work RAM bank for the access |

## Verification
The assertions check the following on every cycle: the select stays one-hot, object RAM stays shut during DMA, video RAM stays shut in mode 3, control writes come only from the lower half of the address space, the hole reads 0xFF, and the bank register never holds 0 and loads correctly. The group comparison can only be shown by the bench's scenarios, because it needs a specific pairing of DMA source and access slice. The same holds for the difference between the two variant tables for the work RAM slice, and for the exemption of the mirror region from DMA blocking.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int BANK_W  = 3;
    localparam int OFF_W   = 14;
    localparam int SLICE_W = 3;
    localparam int NUM_TGT = 10;

    // target index = position in the one-hot select
    localparam int T_ROM0 = 0;
    localparam int T_ROMX = 1;
    localparam int T_VRAM = 2;
    localparam int T_XRAM = 3;
    localparam int T_WRM0 = 4;
    localparam int T_WRMX = 5;
    localparam int T_OAM  = 6;
    localparam int T_IO   = 7;
    localparam int T_HRAM = 8;
    localparam int T_IE   = 9;

    typedef enum logic [1:0] {
        GRP_MAIN = 2'd0,
        GRP_VID  = 2'd1,
        GRP_WRK  = 2'd2,
        GRP_CPU  = 2'd3
    } bus_grp_e;

    typedef struct packed {
        logic [NUM_TGT-1:0] hit;
        logic [OFF_W-1:0]   off;
        logic               bank_reg;
    } dec_t;

    function automatic bus_grp_e slice_group(input logic [SLICE_W-1:0] s,
                                             input logic enh);
        bus_grp_e g;
        case (s)
            3'd4:    g = GRP_VID;
            3'd6:    g = enh ? GRP_WRK : GRP_MAIN;
            3'd7:    g = GRP_CPU;
            default: g = GRP_MAIN;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/memmap_region_dec.sv
module memmap_region_dec
    import memmap_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BANK_ADDR = 16'hFF70
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    always_comb begin
        dec = '0;
        case (addr[15:12])
            4'h0, 4'h1, 4'h2, 4'h3: begin
                dec.hit[T_ROM0] = 1'b1;
                dec.off = addr[13:0];
            end
            4'h4, 4'h5, 4'h6, 4'h7: begin
                dec.hit[T_ROMX] = 1'b1;
                dec.off = addr[13:0];
            end
            4'h8, 4'h9: begin
                dec.hit[T_VRAM] = 1'b1;
                dec.off = OFF_W'(addr[12:0]);
            end
            4'hA, 4'hB: begin
                dec.hit[T_XRAM] = 1'b1;
                dec.off = OFF_W'(addr[12:0]);
            end
            4'hC, 4'hE: begin
                dec.hit[T_WRM0] = 1'b1;
                dec.off = OFF_W'(addr[11:0]);
            end
            4'hD: begin
                dec.hit[T_WRMX] = 1'b1;
                dec.off = OFF_W'(addr[11:0]);
            end
            default: begin
                if (addr < 16'hFE00) begin
                    dec.hit[T_WRMX] = 1'b1;
                    dec.off = OFF_W'(addr[11:0]);
                end else if (addr < 16'hFEA0) begin
                    dec.hit[T_OAM] = 1'b1;
                    dec.off = OFF_W'(addr[7:0]);
                end else if (addr < 16'hFF00) begin
                    dec.hit = '0;
                end else if (addr == BANK_ADDR) begin
                    dec.bank_reg = 1'b1;
                end else if (addr < 16'hFF80) begin
                    dec.hit[T_IO] = 1'b1;
                    dec.off = OFF_W'(addr[6:0]);
                end else if (addr != 16'hFFFF) begin
                    dec.hit[T_HRAM] = 1'b1;
                    dec.off = OFF_W'(addr[6:0]);
                end else begin
                    dec.hit[T_IE] = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/memmap_dma_guard.sv
module memmap_dma_guard
    import memmap_pkg::*;
(
    input  logic [SLICE_W-1:0] cpu_slice,
    input  logic [SLICE_W-1:0] dma_slice,
    input  logic               dma_active,
    input  logic               enh,
    input  logic               oam_hit,
    output logic               blocked
);

    bus_grp_e cpu_grp;
    bus_grp_e dma_grp;
    logic     grp_clash;

    always_comb begin
        cpu_grp   = slice_group(cpu_slice, enh);
        dma_grp   = slice_group(dma_slice, enh);
        grp_clash = (dma_grp != GRP_CPU) && (dma_grp == cpu_grp);
        blocked   = dma_active && (grp_clash || oam_hit);
    end

endmodule

// File: rtl/memmap_vid_gate.sv
module memmap_vid_gate
    import memmap_pkg::*;
(
    input  logic [NUM_TGT-1:0] hit_in,
    input  logic [1:0]         vid_mode,
    output logic [NUM_TGT-1:0] hit_out
);

    logic vram_open;
    logic oam_open;

    assign vram_open = (vid_mode != 2'd3);
    assign oam_open  = (vid_mode < 2'd2);

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_gate
        if (t == T_VRAM) begin : g_vram
            assign hit_out[t] = hit_in[t] & vram_open;
        end else if (t == T_OAM) begin : g_oam
            assign hit_out[t] = hit_in[t] & oam_open;
        end else begin : g_pass
            assign hit_out[t] = hit_in[t];
        end
    end

endmodule

// File: rtl/memmap_wram_bank.sv
module memmap_wram_bank
    import memmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] bank
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bank <= BANK_W'(1);
        end else if (load) begin
            bank <= (wdata == '0) ? BANK_W'(1) : wdata;
        end
    end

    // R3: the bank never reads as zero
    a_r3_bank_nonzero: assert property (@(posedge clk) disable iff (rst)
        bank != '0);

    // R3: a non-zero write is taken as written
    a_r3_bank_load: assert property (@(posedge clk) disable iff (rst)
        (load && wdata != '0) |=> bank == $past(wdata));

    // R3: a zero write becomes bank 1
    a_r3_bank_zero: assert property (@(posedge clk) disable iff (rst)
        (load && wdata == '0) |=> bank == BANK_W'(1));

endmodule

// File: rtl/memmap_steer.sv
module memmap_steer
    import memmap_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BANK_ADDR = 16'hFF70
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hw_enh,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                cpu_rd,
    input  logic                cpu_wr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic [DATA_W-1:0]   cpu_rdata,
    input  logic                dma_active,
    input  logic [SLICE_W-1:0]  dma_slice,
    input  logic [1:0]          vid_mode,
    output logic [NUM_TGT-1:0]  tgt_sel,
    output logic [OFF_W-1:0]    tgt_off,
    output logic                tgt_rd,
    output logic                tgt_wr,
    output logic [DATA_W-1:0]   tgt_wdata,
    input  logic [DATA_W-1:0]   tgt_rdata,
    output logic                ctl_wr,
    output logic [BANK_W-1:0]   wram_page
);

    dec_t               dec;
    logic [NUM_TGT-1:0] gated;
    logic               blocked;
    logic               req;
    logic               rom_hit;
    logic               bank_sel;
    logic               bank_load;
    logic [BANK_W-1:0]  bank;

    memmap_region_dec #(.BANK_ADDR(BANK_ADDR)) dec_i (
        .addr (cpu_addr),
        .dec  (dec)
    );

    memmap_dma_guard guard_i (
        .cpu_slice  (cpu_addr[15:13]),
        .dma_slice  (dma_slice),
        .dma_active (dma_active),
        .enh        (hw_enh),
        .oam_hit    (dec.hit[T_OAM]),
        .blocked    (blocked)
    );

    memmap_vid_gate vgate_i (
        .hit_in   (dec.hit),
        .vid_mode (vid_mode),
        .hit_out  (gated)
    );

    memmap_wram_bank bank_i (
        .clk   (clk),
        .rst   (rst),
        .load  (bank_load),
        .wdata (cpu_wdata[BANK_W-1:0]),
        .bank  (bank)
    );

    always_comb begin
        req       = cpu_rd | cpu_wr;
        tgt_sel   = (req && !blocked) ? gated : '0;
        tgt_off   = dec.off;
        rom_hit   = tgt_sel[T_ROM0] | tgt_sel[T_ROMX];
        tgt_rd    = cpu_rd & (|tgt_sel);
        tgt_wr    = cpu_wr & (|tgt_sel) & ~rom_hit;
        ctl_wr    = cpu_wr & rom_hit;
        tgt_wdata = cpu_wdata;
        bank_sel  = dec.bank_reg & ~blocked;
        bank_load = cpu_wr & bank_sel;
        wram_page = tgt_sel[T_WRMX] ? bank : '0;
        if (|tgt_sel)
            cpu_rdata = tgt_rdata;
        else if (bank_sel)
            cpu_rdata = {{(DATA_W-BANK_W){1'b1}}, bank};
        else
            cpu_rdata = '1;
    end

    // R1: at most one target at a time
    a_r1_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tgt_sel));

    // R10: object RAM closed during DMA
    a_r10_oam_dma: assert property (@(posedge clk) disable iff (rst)
        (dma_active && cpu_addr >= 16'hFE00 && cpu_addr < 16'hFEA0)
        |-> (!tgt_sel[T_OAM] && cpu_rdata == '1));

    // R5: video RAM closed in mode 3
    a_r5_vram_mode3: assert property (@(posedge clk) disable iff (rst)
        (vid_mode == 2'd3) |-> !tgt_sel[T_VRAM]);

    // R4: control writes only from the ROM window, never as target writes
    a_r4_ctl_low: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |-> (!cpu_addr[15] && !tgt_wr));

    // R11: the hole selects nothing and reads all ones
    a_r11_hole: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr >= 16'hFEA0 && cpu_addr < 16'hFF00)
        |-> (tgt_sel == '0 && cpu_rdata == '1));

endmodule

// File: tb/memmap_steer_tb_top.sv
module memmap_steer_tb_top;
    import memmap_pkg::*;

    typedef struct packed {
        logic [15:0] addr;
        logic        wr;
        logic        enh;
        logic        dma;
        logic [15:0] src;
        logic [1:0]  mode;
        logic [9:0]  sel;
        logic [13:0] off;
        logic [7:0]  rdata;
        logic        ctl;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        // R1 plain decode
        '{16'h1234,1'b0,1'b0,1'b0,16'h0000,2'd0,10'h001,14'h1234,8'h5A,1'b0,4'd1},
        '{16'h4567,1'b0,1'b0,1'b0,16'h0000,2'd0,10'h002,14'h0567,8'h5A,1'b0,4'd1},
        '{16'h8ABC,1'b0,1'b0,1'b0,16'h0000,2'd0,10'h004,14'h0ABC,8'h5A,1'b0,4'd1},
        '{16'hB001,1'b0,1'b0,1'b0,16'h0000,2'd0,10'h008,14'h1001,8'h5A,1'b0,4'd1},
        '{16'hC123,1'b0,1'b0,1'b0,16'h0000,2'd0,10'h010,14'h0123,8'h5A,1'b0,4'd1},
        '{16'hD456,1'b0,1'b0,1'b0,16'h0000,2'd0,10'h020,14'h0456,8'h5A,1'b0,4'd1},
        '{16'hFE10,1'b0,1'b0,1'b0,16'h0000,2'd1,10'h040,14'h0010,8'h5A,1'b0,4'd1},
        '{16'hFF0F,1'b0,1'b0,1'b0,16'h0000,2'd0,10'h080,14'h000F,8'h5A,1'b0,4'd1},
        '{16'hFF90,1'b0,1'b0,1'b0,16'h0000,2'd0,10'h100,14'h0010,8'h5A,1'b0,4'd1},
        '{16'hFFFF,1'b0,1'b0,1'b0,16'h0000,2'd0,10'h200,14'h0000,8'h5A,1'b0,4'd1},
        // R2 mirror halves
        '{16'hE010,1'b0,1'b0,1'b0,16'h0000,2'd0,10'h010,14'h0010,8'h5A,1'b0,4'd2},
        '{16'hFD00,1'b0,1'b0,1'b0,16'h0000,2'd0,10'h020,14'h0D00,8'h5A,1'b0,4'd2},
        // R4 control write
        '{16'h2100,1'b1,1'b0,1'b0,16'h0000,2'd0,10'h001,14'h2100,8'h00,1'b1,4'd4},
        // R5 video RAM in mode 3
        '{16'h9000,1'b0,1'b0,1'b0,16'h0000,2'd3,10'h000,14'h0000,8'hFF,1'b0,4'd5},
        // R6 object RAM in modes 2 and 3
        '{16'hFE00,1'b0,1'b0,1'b0,16'h0000,2'd2,10'h000,14'h0000,8'hFF,1'b0,4'd6},
        '{16'hFE00,1'b1,1'b0,1'b0,16'h0000,2'd3,10'h000,14'h0000,8'h00,1'b0,4'd6},
        // R11 hole
        '{16'hFEA0,1'b0,1'b0,1'b0,16'h0000,2'd0,10'h000,14'h0000,8'hFF,1'b0,4'd11},
        // R7 basic table: work RAM source blocks main
        '{16'h0100,1'b0,1'b0,1'b1,16'hC000,2'd0,10'h000,14'h0000,8'hFF,1'b0,4'd7},
        // R8 enhanced table: separate work RAM group
        '{16'h0100,1'b0,1'b1,1'b1,16'hC000,2'd0,10'h001,14'h0100,8'h5A,1'b0,4'd8},
        '{16'hD000,1'b0,1'b1,1'b1,16'hC000,2'd0,10'h000,14'h0000,8'hFF,1'b0,4'd8},
        // R7 video source
        '{16'h9F00,1'b0,1'b0,1'b1,16'h8000,2'd0,10'h000,14'h0000,8'hFF,1'b0,4'd7},
        '{16'hC000,1'b0,1'b0,1'b1,16'h8000,2'd0,10'h010,14'h0000,8'h5A,1'b0,4'd7},
        // R9 CPU-internal group never blocks
        '{16'hE000,1'b0,1'b0,1'b1,16'hC000,2'd0,10'h010,14'h0000,8'h5A,1'b0,4'd9},
        '{16'hFF80,1'b0,1'b0,1'b1,16'hF000,2'd0,10'h100,14'h0000,8'h5A,1'b0,4'd9},
        // R10 object RAM during DMA
        '{16'hFE20,1'b0,1'b0,1'b1,16'h8000,2'd0,10'h000,14'h0000,8'hFF,1'b0,4'd10},
        // R7 blocked control write
        '{16'h2000,1'b1,1'b0,1'b1,16'h0000,2'd0,10'h000,14'h0000,8'h00,1'b0,4'd7}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hw_enh = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        dma_active = 1'b0;
    logic [2:0]  dma_slice = '0;
    logic [1:0]  vid_mode = '0;
    logic [9:0]  tgt_sel;
    logic [13:0] tgt_off;
    logic        tgt_rd;
    logic        tgt_wr;
    logic [7:0]  tgt_wdata;
    logic [7:0]  tgt_rdata = 8'h5A;
    logic        ctl_wr;
    logic [2:0]  wram_page;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    memmap_steer dut_i (
        .clk(clk), .rst(rst), .hw_enh(hw_enh), .cpu_addr(cpu_addr),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .dma_active(dma_active), .dma_slice(dma_slice),
        .vid_mode(vid_mode), .tgt_sel(tgt_sel), .tgt_off(tgt_off),
        .tgt_rd(tgt_rd), .tgt_wr(tgt_wr), .tgt_wdata(tgt_wdata),
        .tgt_rdata(tgt_rdata), .ctl_wr(ctl_wr), .wram_page(wram_page)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0; dma_active = 1'b0;
        hw_enh = 1'b0; vid_mode = 2'd0;
    endtask

    task automatic bank_write(input logic [7:0] d, input logic dma, input logic [15:0] src);
        @(negedge clk);
        cpu_addr = 16'hFF70; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        dma_active = dma; dma_slice = src[15:13];
        @(posedge clk);
        idle();
    endtask

    task automatic bank_read(input logic [7:0] exp, input string req);
        @(negedge clk);
        cpu_addr = 16'hFF70; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #1;
        check(req, "bank read", cpu_rdata, exp);
        check(req, "bank sel none", tgt_sel, 0);
        idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R3 reset value
        bank_read(8'hF9, "R3");

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [31:0] exp_wen;
            string rq;
            @(negedge clk);
            cpu_addr = VEC[i].addr; cpu_wr = VEC[i].wr; cpu_rd = ~VEC[i].wr;
            hw_enh = VEC[i].enh; dma_active = VEC[i].dma;
            dma_slice = VEC[i].src[15:13]; vid_mode = VEC[i].mode;
            cpu_wdata = 8'hA5;
            #1;
            rq = $sformatf("R%0d row%0d", VEC[i].req, i);
            check(rq, "sel", tgt_sel, VEC[i].sel);
            if (VEC[i].sel != 0) check(rq, "off", tgt_off, VEC[i].off);
            if (!VEC[i].wr) begin
                check(rq, "rdata", cpu_rdata, VEC[i].rdata);
                check(rq, "rd strobe", tgt_rd, (VEC[i].sel != 0));
            end else begin
                exp_wen = ((VEC[i].sel != 0) && !VEC[i].ctl) ? 1 : 0;
                check(rq, "wr strobe", tgt_wr, exp_wen);
                check(rq, "ctl_wr", ctl_wr, VEC[i].ctl);
                if (tgt_wr) check(rq, "wdata", tgt_wdata, 8'hA5);
            end
        end
        idle();

        // R3 bank writes, clamp and zero rule
        bank_write(8'h05, 1'b0, 16'h0000);
        bank_read(8'hFD, "R3");
        @(negedge clk);
        cpu_addr = 16'hD010; cpu_rd = 1'b1;
        #1;
        check("R3", "page in switchable window", wram_page, 5);
        cpu_addr = 16'hC010;
        #1;
        check("R3", "page in fixed window", wram_page, 0);
        idle();
        bank_write(8'h00, 1'b0, 16'h0000);
        bank_read(8'hF9, "R3");
        bank_write(8'h0F, 1'b0, 16'h0000);
        bank_read(8'hFF, "R3");
        // R9 bank register reachable during DMA from work RAM
        bank_write(8'h02, 1'b1, 16'hC000);
        bank_read(8'hFA, "R9");

        // R12 read data passthrough with a different pattern
        @(negedge clk);
        tgt_rdata = 8'h3C; cpu_addr = 16'hA000; cpu_rd = 1'b1;
        #1;
        check("R12", "passthrough", cpu_rdata, 8'h3C);
        check("R12", "ext sel", tgt_sel, 10'h008);
        tgt_rdata = 8'h5A;
        idle();

        // R5 write to video RAM in mode 3 dropped, allowed in mode 2
        @(negedge clk);
        cpu_addr = 16'h8800; cpu_wr = 1'b1; vid_mode = 2'd3;
        #1;
        check("R5", "vram write mode3", tgt_wr, 0);
        @(negedge clk);
        vid_mode = 2'd2;
        #1;
        check("R5", "vram write mode2", tgt_wr, 1);
        idle();

        // R4 no request, no select
        @(negedge clk);
        cpu_addr = 16'h1000;
        #1;
        check("R1", "idle sel", tgt_sel, 0);
        check("R4", "idle ctl", ctl_wr, 0);

        // R3 reset restores bank 1
        bank_write(8'h06, 1'b0, 16'h0000);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        bank_read(8'hF9, "R3");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule